// File: doc/BRIEF.md
# M-ary continuous-phase FSK phase generator

This block turns a serial bit stream into the running phase of a continuous-phase frequency-shift-keyed carrier. Bits arrive one per handshake. They are gathered into symbols of one, two or three bits, and each symbol is mapped to a signed frequency level. The deviation for that level is scaled by a fixed-point modulation index and by a power-of-two symbol period. That deviation and a signed carrier increment are added into a 32-bit phase accumulator on every processing clock. A sine lookup downstream turns the phase word into a waveform.

Configuration is sampled only at symbol boundaries, and the accumulator is never cleared after reset, so the phase has no steps. In burst operation the generator stops and freezes its phase when it runs out of data. In continuous operation it fills the gap with a zero-deviation symbol, and the carrier keeps turning. Codes that name a Gaussian-shaped alphabet are produced here with rectangular pulses.

Top module: `cpfsk_phase_mod`

## Requirements
- R1: During reset and on the first cycle after it, `phase_word` is 0, `phase_valid` is 0 and `bit_ready` is 1.
- R2: A symbol lasts exactly 2^n clocks with `phase_valid` high, where n is `rate_exp` (0 to 15).
- R3: `mod_type` sets the bits per symbol: codes 0 and 1 use 1 bit, codes 2 and 3 use 2 bits, codes 4 and 5 use 3 bits. The first bit received is the most significant bit of the symbol value k, and the level is a = 2k − (2^bits − 1).
- R4: While a symbol plays, each valid clock adds `carrier_step` + `mod_index`·a·2^(23−n) to the phase, modulo 2^32. `mod_index` holds 3 integer bits and 8 fraction bits, so one whole symbol adds `mod_index`·a·2^23 + 2^n·`carrier_step`.
- R5: Codes 1, 3 and 5 give the same phase sequence as codes 0, 2 and 4.
- R6: In burst mode (`cont_mode` = 0), if no complete symbol is buffered at a boundary, `phase_valid` goes low and `phase_word` holds its value.
- R7: In continuous mode (`cont_mode` = 1), if no complete symbol is buffered at a boundary, a zero-level symbol plays. `phase_valid` stays high and the phase advances by exactly `carrier_step` on each clock.
- R8: `carrier_step`, `rate_exp` and `mod_index` are taken only at a symbol boundary. A change made during a symbol first shows in the accumulation of the clock that follows the boundary. Until then, from 1 to 2^n_old more steps use the old value.
- R9: `bit_ready` is low while a complete symbol is buffered and waiting for a boundary. It stays low until that symbol is taken.
- R10: The longest period (n = 15, 32768 clocks per symbol) gives the R4 phase advance over one symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_data | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_data` is offered |
| bit_ready | output | 1 | The block takes the offered bit this clock |
| mod_type | input | 3 | Alphabet code (0..5) |
| rate_exp | input | 4 | Symbol period exponent n |
| mod_index | input | 11 | Modulation index h, 3.8 unsigned fixed point |
| carrier_step | input | 32 | Signed carrier phase increment per clock |
| cont_mode | input | 1 | 0 = burst, 1 = continuous |
| phase_word | output | 32 | Accumulated phase |
| phase_valid | output | 1 | `phase_word` holds a new sample |

## Verification
A symbol boundary can fall on the same clock as a configuration change. It can also fall on the same clock as a data underrun, where the bit packer has not yet filled a symbol. The bench provokes the first case by changing `carrier_step` at an arbitrary clock while continuous mode plays idle symbols. It then counts how many per-clock phase differences still equal the old increment, and that count must be between 1 and the old period. The second case comes from short periods with wide alphabets (n = 0 or 1 with 4 or 8 levels), where the packer cannot keep up. The bench judges it by counting only valid samples and requiring the phase after each symbol to match the sum computed from the bit pattern, with the phase frozen during the gaps.

// File: rtl/cpfsk_pkg.sv
// Shared helpers for the CPFSK phase generator: alphabet codes,
// bits-per-symbol decoding and the bit-value to level mapping.
// Assumes alphabets of at most 8 levels (3 bits per symbol).
package cpfsk_pkg;

    typedef enum logic [2:0] {
        MT_FSK2  = 3'd0,
        MT_GFSK2 = 3'd1,
        MT_FSK4  = 3'd2,
        MT_GFSK4 = 3'd3,
        MT_FSK8  = 3'd4,
        MT_GFSK8 = 3'd5
    } mod_type_e;

    // Number of data bits carried by one symbol; Gaussian codes share
    // the count of their rectangular partner, unknown codes use 1.
    function automatic logic [1:0] bits_per_sym(input logic [2:0] code);
        case (mod_type_e'(code))
            MT_FSK4, MT_GFSK4: return 2'd2;
            MT_FSK8, MT_GFSK8: return 2'd3;
            default:           return 2'd1;
        endcase
    endfunction

    // Odd-integer level 2k - (M-1) for symbol value k and M = 2^bps.
    function automatic logic signed [3:0] level_of(input logic [2:0] k,
                                                   input logic [1:0] bps);
        logic signed [4:0] twice;
        twice = signed'({1'b0, k, 1'b0});
        case (bps)
            2'd2:    twice = twice - 5'sd3;
            2'd3:    twice = twice - 5'sd7;
            default: twice = twice - 5'sd1;
        endcase
        return signed'(twice[3:0]);
    endfunction

endpackage

// File: rtl/cpfsk_sym_timer.sv
// Symbol period counter. Counts clocks within a symbol and flags the
// last one. Assumes the period exponent is held stable between restarts;
// a restart puts the counter back to the first clock of a symbol.
module cpfsk_sym_timer #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             sym_last
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;

    // Period length 2^n as a wide constant for the end-of-symbol compare.
    always_comb begin
        span     = (CNT_W + 1)'(1) << exp_sel;
        sym_last = ({1'b0, cnt} == (span - 1'b1));
    end

    // Clock counter: restart at a boundary, otherwise count up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpfsk_bit_packer.sv
// Serial-to-symbol packer. Accepts one bit per handshake, first bit as
// MSB, until the symbol width is reached, then holds the symbol and
// refuses bits until it is taken. Assumes take is raised only when full.
module cpfsk_bit_packer #(
    parameter int SYM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_data,
    input  logic             bit_valid,
    input  logic [1:0]       bps,
    input  logic             take,
    output logic             ready,
    output logic             full,
    output logic [SYM_W-1:0] sym_bits
);
    logic [1:0]       fill;
    logic [SYM_W-1:0] shreg;

    // Full once as many bits as the alphabet needs have been collected.
    always_comb begin
        full     = (fill >= bps);
        ready    = !full;
        sym_bits = shreg;
    end

    // Shift register and fill count; cleared when the symbol is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill  <= '0;
            shreg <= '0;
        end else if (take) begin
            fill  <= '0;
            shreg <= '0;
        end else if (bit_valid && ready) begin
            shreg <= {shreg[SYM_W-2:0], bit_data};
            fill  <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/cpfsk_dev_scale.sv
// Deviation scaler. Produces the per-clock phase step index*level
// shifted so that 2^n steps add index*level*2^(PHASE_W-1-H_FRAC).
// Assumes PHASE_W-1-H_FRAC >= 2^EXP_W - 1 so the shift never goes negative.
module cpfsk_dev_scale #(
    parameter int PHASE_W = 32,
    parameter int H_W     = 11,
    parameter int H_FRAC  = 8,
    parameter int EXP_W   = 4,
    parameter int LVL_W   = 4
) (
    input  logic [H_W-1:0]         index,
    input  logic signed [LVL_W-1:0] level,
    input  logic [EXP_W-1:0]       rate_exp,
    output logic [PHASE_W-1:0]     step
);
    localparam int PROD_W = H_W + 1 + LVL_W;
    localparam int BASE   = PHASE_W - 1 - H_FRAC;
    localparam int SH_W   = $clog2(PHASE_W) + 1;

    logic signed [PROD_W-1:0]  prod;
    logic signed [PHASE_W-1:0] wide;
    logic [SH_W-1:0]           shamt;

    // Signed product, sign extension, then a power-of-two scale by 2^(BASE-n).
    always_comb begin
        prod  = PROD_W'($signed({1'b0, index})) * PROD_W'(level);
        wide  = PHASE_W'(prod);
        shamt = SH_W'(BASE) - SH_W'(rate_exp);
        step  = wide << shamt;
    end
endmodule

// File: rtl/cpfsk_phase_mod.sv
// CPFSK phase generator top. Samples configuration at each symbol
// boundary, maps buffered bits to a level, and accumulates carrier plus
// deviation every active clock. Assumes mod_type changes only while the
// packer is empty; the accumulator is cleared by reset alone.
module cpfsk_phase_mod
    import cpfsk_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int H_W     = 11,
    parameter int H_FRAC  = 8,
    parameter int EXP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_data,
    input  logic               bit_valid,
    output logic               bit_ready,
    input  logic [2:0]         mod_type,
    input  logic [EXP_W-1:0]   rate_exp,
    input  logic [H_W-1:0]     mod_index,
    input  logic [PHASE_W-1:0] carrier_step,
    input  logic               cont_mode,
    output logic [PHASE_W-1:0] phase_word,
    output logic               phase_valid
);
    localparam int SYM_W = 3;
    localparam int LVL_W = 4;

    logic                    active;
    logic                    sym_last;
    logic                    boundary;
    logic                    take;
    logic                    sym_full;
    logic [SYM_W-1:0]        sym_bits;
    logic [1:0]              bps;
    logic signed [LVL_W-1:0] new_level;
    logic signed [LVL_W-1:0] level_r;
    logic [EXP_W-1:0]        exp_r;
    logic [H_W-1:0]          h_r;
    logic [PHASE_W-1:0]      car_r;
    logic [PHASE_W-1:0]      dev_step;
    logic [PHASE_W-1:0]      acc;

    // Boundary decode and level mapping of the buffered symbol.
    always_comb begin
        bps       = bits_per_sym(mod_type);
        new_level = level_of(sym_bits, bps);
        boundary  = !active || sym_last;
        take      = boundary && sym_full;
    end

    cpfsk_sym_timer #(.EXP_W(EXP_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (boundary),
        .exp_sel  (exp_r),
        .sym_last (sym_last)
    );

    cpfsk_bit_packer #(.SYM_W(SYM_W)) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_data  (bit_data),
        .bit_valid (bit_valid),
        .bps       (bps),
        .take      (take),
        .ready     (bit_ready),
        .full      (sym_full),
        .sym_bits  (sym_bits)
    );

    cpfsk_dev_scale #(
        .PHASE_W (PHASE_W),
        .H_W     (H_W),
        .H_FRAC  (H_FRAC),
        .EXP_W   (EXP_W),
        .LVL_W   (LVL_W)
    ) scale_i (
        .index    (h_r),
        .level    (level_r),
        .rate_exp (exp_r),
        .step     (dev_step)
    );

    // Symbol control: latch configuration and pick data, idle or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            level_r <= '0;
            exp_r   <= '0;
            h_r     <= '0;
            car_r   <= '0;
        end else if (boundary) begin
            exp_r <= rate_exp;
            h_r   <= mod_index;
            car_r <= carrier_step;
            if (sym_full) begin
                level_r <= new_level;
                active  <= 1'b1;
            end else if (cont_mode) begin
                level_r <= '0;
                active  <= 1'b1;
            end else begin
                active  <= 1'b0;
            end
        end
    end

    // Phase accumulator and its valid flag; advances only while a symbol plays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc         <= '0;
            phase_valid <= 1'b0;
        end else begin
            if (active) begin
                acc <= acc + car_r + dev_step;
            end
            phase_valid <= active;
        end
    end

    assign phase_word = acc;
endmodule

// File: rtl/cpfsk_phase_mod_chk.sv
// Property checker for cpfsk_phase_mod, attached by bind. Observes ports
// and the boundary and active state; drives nothing.
module cpfsk_phase_mod_chk #(
    parameter int PHASE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_ready,
    input logic               phase_valid,
    input logic [PHASE_W-1:0] phase_word,
    input logic               cont_mode,
    input logic               boundary,
    input logic               active
);
    // R1: reset leaves outputs cleared and ready raised.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (phase_word == '0 && !phase_valid && bit_ready));

    // R6: no valid sample means the phase did not move.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_valid |-> $stable(phase_word));

    // R7: with continuous mode held, the output never drops valid.
    p_cont_keeps_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_mode && $stable(cont_mode) && phase_valid) |=> phase_valid);

    // R9: a held symbol keeps ready low until a boundary takes it.
    p_ready_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_ready && !boundary) |=> !bit_ready);

    // R2: a playing symbol yields a valid sample on the next clock.
    p_active_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> phase_valid);
endmodule

bind cpfsk_phase_mod cpfsk_phase_mod_chk #(.PHASE_W(PHASE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_ready   (bit_ready),
    .phase_valid (phase_valid),
    .phase_word  (phase_word),
    .cont_mode   (cont_mode),
    .boundary    (boundary),
    .active      (active)
);

// File: tb/cpfsk_phase_mod_tb.sv
module cpfsk_phase_mod_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_data = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_ready;
    logic [2:0]  mod_type = 3'd0;
    logic [3:0]  rate_exp = 4'd0;
    logic [10:0] mod_index = 11'd0;
    logic [31:0] carrier_step = 32'd0;
    logic        cont_mode = 1'b0;
    logic [31:0] phase_word;
    logic        phase_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpfsk_phase_mod dut_i (
        .clk(clk), .rst_n(rst_n), .bit_data(bit_data), .bit_valid(bit_valid),
        .bit_ready(bit_ready), .mod_type(mod_type), .rate_exp(rate_exp),
        .mod_index(mod_index), .carrier_step(carrier_step), .cont_mode(cont_mode),
        .phase_word(phase_word), .phase_valid(phase_valid)
    );

    // type(3) n(4) h(11) carrier(32) bits(24, first bit at 23) nsym(4)
    localparam int NV = 7;
    localparam logic [77:0] VEC [NV] = '{
        {3'd0, 4'd2,  11'h080, 32'h0000_0000, 24'hA5C300, 4'd8},   // R3 R4 2-level MSK
        {3'd2, 4'd3,  11'h100, 32'h0100_0000, 24'h1BE472, 4'd6},   // R3 R4 4-level
        {3'd4, 4'd2,  11'h3FF, 32'hFFF0_0000, 24'hFAC688, 4'd8},   // R3 R4 8-level, negative carrier
        {3'd5, 4'd1,  11'h155, 32'h0000_0000, 24'h05397F, 4'd8},   // R5 Gaussian 8, packer gaps
        {3'd3, 4'd0,  11'h7FF, 32'h8000_0001, 24'hE41B6C, 4'd12},  // R5 Gaussian 4, n=0
        {3'd1, 4'd4,  11'h080, 32'h0000_007B, 24'h3C9600, 4'd8},   // R5 Gaussian 2
        {3'd0, 4'd15, 11'h080, 32'h0000_0001, 24'h800000, 4'd1}    // R10 longest period
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_bits(input logic [23:0] pat, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            bit_valid = 1'b1;
            bit_data  = pat[23-i];
            while (!bit_ready) @(negedge clk);
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic run_vec(input logic [77:0] v);
        logic [2:0]  ty;
        logic [3:0]  n;
        logic [10:0] h;
        logic [31:0] car;
        logic [23:0] pat;
        int          ns;
        int          b;
        logic [31:0] expv;
        ty = v[77:75]; n = v[74:71]; h = v[70:60]; car = v[59:28];
        pat = v[27:4]; ns = int'(v[3:0]);
        b = (ty >= 3'd4) ? 3 : (ty >= 3'd2) ? 2 : 1;
        mod_type = ty; rate_exp = n; mod_index = h; carrier_step = car;
        @(negedge clk);
        expv = phase_word;
        fork
            drive_bits(pat, ns * b);
            begin
                int samp = 0;
                int sym = 0;
                while (sym < ns) begin
                    @(negedge clk);
                    if (phase_valid) begin
                        samp++;
                        if (samp == (1 << n)) begin
                            int k;
                            longint a;
                            k = int'((pat >> (24 - (sym + 1) * b)) & ((24'd1 << b) - 1));
                            a = longint'(2 * k - ((1 << b) - 1));
                            expv = expv + 32'((longint'(h) * a) << 23) + (car << n);
                            // R2 R3 R4 R5: phase after each whole symbol
                            check(phase_word == expv, "R4 symbol phase", phase_word, expv);
                            samp = 0;
                            sym++;
                        end
                    end
                end
            end
        join
        // R6: out of data in burst mode, valid drops and phase holds
        repeat (3) @(negedge clk);
        check(!phase_valid, "R6 valid low", 32'(phase_valid), 32'd0);
        expv = phase_word;
        repeat (5) @(negedge clk);
        check(phase_word == expv, "R6 phase held", phase_word, expv);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        logic [31:0] c1;
        logic [31:0] c2;
        int          old_cnt;
        bit          seen_new;
        bit          ok;
        repeat (3) @(negedge clk);
        // R1: during reset
        check(phase_word == 0 && !phase_valid && bit_ready, "R1 in reset",
              {phase_word[29:0], phase_valid, bit_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase_word == 0 && !phase_valid && bit_ready, "R1 after reset",
              {phase_word[29:0], phase_valid, bit_ready}, 32'd1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: a buffered symbol holds ready low while the previous one plays
        mod_type = 3'd4; rate_exp = 4'd5; mod_index = 11'h040; carrier_step = 32'd0;
        @(negedge clk);
        drive_bits(24'hB40000, 6);
        check(!bit_ready, "R9 ready low when full", 32'(bit_ready), 32'd0);
        repeat (3) @(negedge clk);
        check(!bit_ready, "R9 ready stays low", 32'(bit_ready), 32'd0);
        repeat (80) @(negedge clk);
        check(bit_ready && !phase_valid, "R9 drained", {30'd0, bit_ready, phase_valid}, 32'd2);

        // R7: continuous mode with no data plays zero-level symbols
        c1 = 32'h0123_4567;
        rate_exp = 4'd2; carrier_step = c1; mod_index = 11'h7FF; cont_mode = 1'b1;
        repeat (4) @(negedge clk);
        ok = 1'b1;
        prev = phase_word;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!phase_valid || (phase_word - prev) != c1) ok = 1'b0;
            prev = phase_word;
        end
        check(ok, "R7 idle step equals carrier", phase_word - prev, c1);
        check(phase_valid, "R7 valid held", 32'(phase_valid), 32'd1);

        // R8: a mid-symbol carrier change lands only after the boundary
        c2 = 32'h0FED_0000;
        repeat (2) @(negedge clk);
        carrier_step = c2;
        rate_exp = 4'd3;
        prev = phase_word;
        old_cnt = 0; seen_new = 1'b0; ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if ((phase_word - prev) == c1) begin
                if (seen_new) ok = 1'b0;
                old_cnt++;
            end else if ((phase_word - prev) == c2) begin
                seen_new = 1'b1;
            end else begin
                ok = 1'b0;
            end
            prev = phase_word;
        end
        check(ok && seen_new, "R8 steps old then new", 32'(old_cnt), 32'd0);
        check(old_cnt >= 1 && old_cnt <= 4, "R8 old steps in 1..4", 32'(old_cnt), 32'd4);

        // R6: back to burst mode, the idle stream stops
        cont_mode = 1'b0; carrier_step = 32'd0;
        repeat (12) @(negedge clk);
        check(!phase_valid, "R6 burst stop", 32'(phase_valid), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule